// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Triggers

This block is a 32-pin general-purpose I/O bank. Software reaches it through a simple register port: a write strobe, a 3-bit word index and 32-bit write data, with read data returned combinationally for the selected word. Each pin can drive its pad from a data register bit or act as an input. Every input passes through a two-flop synchroniser, and the synchronised levels can be read back.

Each pin has its own interrupt trigger. A 2-bit code selects low level, high level, rising edge or falling edge. A separate per-pin bit can override that code and detect both edges. A detected condition latches a status bit, whether or not the pin is masked. Software clears status bits by writing ones to them. A mask register gates which latched bits reach the two interrupt lines. Line 0 serves the lower half of the pins and line 1 the upper half.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is asserted, the data, output-enable, mask, edge-select, status and both trigger-code registers read 0, `pad_oe_o` is 0 and `irq_o` is 0.
- R2: Registers are selected by word index (byte offset = 4 × index): 0 data, 1 output enable, 2 pad status, 3 lower trigger codes, 4 upper trigger codes, 5 mask, 6 status, 7 edge select. All of them except pad status read back the last value written.
- R3: Bit n of `pad_out_o` follows bit n of the data register, and bit n of `pad_oe_o` follows bit n of the output-enable register (1 = drive, 0 = input). Both update on the clock edge that accepts the write.
- R4: Reading index 2 returns the pad inputs delayed by two clock edges. Writes to index 2 have no effect.
- R5: Pin n takes its 2-bit trigger code from bits [2(n mod 16)+1 : 2(n mod 16)] of index 3 when n < 16, and of index 4 otherwise. Code 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
- R6: When bit n of the edge-select register is 1, pin n detects both rising and falling edges, and its trigger code has no effect.
- R7: A detected condition sets its status bit whether or not the pin is masked. A pad change is visible in status on the third clock edge after it.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a condition is detected in the same cycle as the clear, the bit stays set.
- R9: `irq_o[0]` is the OR of (status AND mask) over pins 0–15, and `irq_o[1]` is the same OR over pins 16–31. With the mask at 0, both lines stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the selected register |
| reg_sel_i | input | 3 | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| pad_in_i | input | 32 | Pad input levels (asynchronous) |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_o | output | 2 | Interrupt lines for the lower and upper pin halves |

## Verification
The bench builds the bank with its default 32 pins and a 32-bit data word. At that size the two trigger-code registers are fully packed, and each interrupt line covers exactly 16 pins. This lets the bench reach pin 31, whose field sits in the top bits of the upper code register, alongside pins 0–2 in the lower one. It also lets it raise each interrupt line on its own and then both together. The fixed two-flop plus edge-register pipeline makes every status update land on a known clock edge, so the bench can check the set-wins-over-clear rule cycle by cycle.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam logic [2:0] IDX_DATA   = 3'd0;
  localparam logic [2:0] IDX_OE     = 3'd1;
  localparam logic [2:0] IDX_PAD    = 3'd2;
  localparam logic [2:0] IDX_CFG_LO = 3'd3;
  localparam logic [2:0] IDX_CFG_HI = 3'd4;
  localparam logic [2:0] IDX_MASK   = 3'd5;
  localparam logic [2:0] IDX_STAT   = 3'd6;
  localparam logic [2:0] IDX_EDGE   = 3'd7;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect
  import gpio_bank_pkg::*;
#(
  parameter int PIN_CNT = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIN_CNT-1:0]   level_i,
  input  logic [2*PIN_CNT-1:0] code_i,
  input  logic [PIN_CNT-1:0]   both_i,
  output logic [PIN_CNT-1:0]   hit_o
);
  logic [PIN_CNT-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  for (genvar k = 0; k < PIN_CNT; k++) begin : g_pin
    trig_e code;
    logic  rise, fall, code_hit;

    assign code = trig_e'(code_i[2*k +: 2]);
    assign rise = level_i[k] & ~prev_q[k];
    assign fall = ~level_i[k] & prev_q[k];

    always_comb begin
      unique case (code)
        TRIG_LOW:  code_hit = ~level_i[k];
        TRIG_HIGH: code_hit = level_i[k];
        TRIG_RISE: code_hit = rise;
        default:   code_hit = fall;
      endcase
    end

    // both-edges bit overrides the code
    assign hit_o[k] = both_i[k] ? (rise | fall) : code_hit;
  end
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int PIN_CNT = 32,
  parameter int DW      = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [2:0]           idx_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [PIN_CNT-1:0]   hit_i,
  input  logic [PIN_CNT-1:0]   pad_lvl_i,
  output logic [DW-1:0]        rdata_o,
  output logic [PIN_CNT-1:0]   data_o,
  output logic [PIN_CNT-1:0]   oe_o,
  output logic [2*PIN_CNT-1:0] code_o,
  output logic [PIN_CNT-1:0]   mask_o,
  output logic [PIN_CNT-1:0]   status_o,
  output logic [PIN_CNT-1:0]   edge_o
);
  localparam int HALF = PIN_CNT / 2;
  localparam int CW   = 2 * HALF;

  logic [PIN_CNT-1:0] data_q, oe_q, mask_q, stat_q, edge_q, stat_clr;
  logic [CW-1:0]      cfg_lo_q, cfg_hi_q;
  logic [PIN_CNT-1:0] wpins;
  logic [CW-1:0]      wcfg;

  assign wpins    = wdata_i[PIN_CNT-1:0];
  assign wcfg     = wdata_i[CW-1:0];
  assign stat_clr = (wr_i && idx_i == IDX_STAT) ? wpins : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      oe_q     <= '0;
      mask_q   <= '0;
      edge_q   <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
    end else if (wr_i) begin
      unique case (idx_i)
        IDX_DATA:   data_q   <= wpins;
        IDX_OE:     oe_q     <= wpins;
        IDX_CFG_LO: cfg_lo_q <= wcfg;
        IDX_CFG_HI: cfg_hi_q <= wcfg;
        IDX_MASK:   mask_q   <= wpins;
        IDX_EDGE:   edge_q   <= wpins;
        default: ;
      endcase
    end
  end

  // set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr) | hit_i;
  end

  always_comb begin
    unique case (idx_i)
      IDX_DATA:   rdata_o = DW'(data_q);
      IDX_OE:     rdata_o = DW'(oe_q);
      IDX_PAD:    rdata_o = DW'(pad_lvl_i);
      IDX_CFG_LO: rdata_o = DW'(cfg_lo_q);
      IDX_CFG_HI: rdata_o = DW'(cfg_hi_q);
      IDX_MASK:   rdata_o = DW'(mask_q);
      IDX_STAT:   rdata_o = DW'(stat_q);
      default:    rdata_o = DW'(edge_q);
    endcase
  end

  assign data_o   = data_q;
  assign oe_o     = oe_q;
  assign code_o   = {cfg_hi_q, cfg_lo_q};
  assign mask_o   = mask_q;
  assign status_o = stat_q;
  assign edge_o   = edge_q;

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> ((status_o & $past(hit_i)) == $past(hit_i)));

  a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == IDX_STAT) |=> ((status_o & $past(wpins & ~hit_i)) == '0));

  a_r3_oe_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == IDX_OE) |=> (oe_o == $past(wpins)));
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank #(
  parameter int PIN_CNT = 32,
  parameter int DW      = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         reg_sel_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [PIN_CNT-1:0] pad_in_i,
  output logic [PIN_CNT-1:0] pad_out_o,
  output logic [PIN_CNT-1:0] pad_oe_o,
  output logic [1:0]         irq_o
);
  localparam int HALF = PIN_CNT / 2;

  logic [PIN_CNT-1:0]   lvl, hit, mask, status, both, masked;
  logic [2*PIN_CNT-1:0] code;

  gpio_sync #(.WIDTH(PIN_CNT)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (lvl)
  );

  gpio_trig_detect #(.PIN_CNT(PIN_CNT)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (lvl),
    .code_i  (code),
    .both_i  (both),
    .hit_o   (hit)
  );

  gpio_regs #(.PIN_CNT(PIN_CNT), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i),
    .idx_i     (reg_sel_i),
    .wdata_i   (wdata_i),
    .hit_i     (hit),
    .pad_lvl_i (lvl),
    .rdata_o   (rdata_o),
    .data_o    (pad_out_o),
    .oe_o      (pad_oe_o),
    .code_o    (code),
    .mask_o    (mask),
    .status_o  (status),
    .edge_o    (both)
  );

  assign masked = status & mask;

  for (genvar l = 0; l < 2; l++) begin : g_irq
    assign irq_o[l] = |masked[l*HALF +: HALF];
  end

  a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> (irq_o == 2'b00));
endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  import gpio_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [1:0]  irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam int OBS_RD = 0, OBS_IRQ = 1, OBS_OUT = 2, OBS_OE = 3;

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  gpio_irq_bank uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .reg_sel_i (reg_sel),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .pad_in_i  (pad_in),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe),
    .irq_o     (irq)
  );

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.sel)
          OBS_RD:  act = rdata;
          OBS_IRQ: act = {30'b0, irq};
          OBS_OUT: act = pad_out;
          default: act = pad_oe;
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic drv_write(input logic [2:0] idx, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; reg_sel = idx; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic exp_rd(input logic [2:0] idx, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    reg_sel = idx;
    it.tag = tag; it.sel = OBS_RD; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic exp_port(input int sel, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    it.tag = tag; it.sel = sel; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic drv_pads(input logic [31:0] v);
    @(posedge clk); #2;
    pad_in = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state, observed while reset is held
    exp_rd(IDX_DATA, 32'h0, "R1 data");
    exp_rd(IDX_OE,   32'h0, "R1 oe");
    exp_rd(IDX_MASK, 32'h0, "R1 mask");
    exp_rd(IDX_STAT, 32'h0, "R1 status");
    exp_rd(IDX_EDGE, 32'h0, "R1 edge");
    exp_rd(IDX_CFG_LO, 32'h0, "R1 cfg_lo");
    exp_port(OBS_OE,  32'h0, "R1 pad_oe");
    exp_port(OBS_IRQ, 32'h0, "R1 irq");
    @(posedge clk); #2;
    rst_n = 1'b1;

    // R7: default code 0 (low level) with pads low sets status while masked
    settle();
    exp_rd(IDX_STAT, 32'hFFFF_FFFF, "R7 masked set");
    exp_port(OBS_IRQ, 32'h0, "R9 mask zero quiet");

    // R3 / R2 output path and readback
    drv_write(IDX_OE, 32'h0000_FF0F);
    drv_write(IDX_DATA, 32'hA5A5_1234);
    exp_port(OBS_OUT, 32'hA5A5_1234, "R3 pad_out");
    exp_port(OBS_OE,  32'h0000_FF0F, "R3 pad_oe");
    exp_rd(IDX_DATA, 32'hA5A5_1234, "R2 data readback");
    exp_rd(IDX_OE,   32'h0000_FF0F, "R2 oe readback");

    // R4 pad status latency and write immunity
    drv_pads(32'h1234_5678);
    settle();
    exp_rd(IDX_PAD, 32'h1234_5678, "R4 pad level");
    drv_pads(32'h0F0F_0000);
    exp_rd(IDX_PAD, 32'h1234_5678, "R4 one edge old");
    exp_rd(IDX_PAD, 32'h0F0F_0000, "R4 two edges new");
    drv_write(IDX_PAD, 32'hFFFF_FFFF);
    exp_rd(IDX_PAD, 32'h0F0F_0000, "R4 write ignored");

    // high level on all pins, clear everything
    drv_pads(32'h0);
    settle();
    drv_write(IDX_CFG_LO, 32'h5555_5555);
    drv_write(IDX_CFG_HI, 32'h5555_5555);
    drv_write(IDX_STAT, 32'hFFFF_FFFF);
    exp_rd(IDX_STAT, 32'h0, "R8 w1c all");
    exp_rd(IDX_CFG_HI, 32'h5555_5555, "R2 cfg_hi readback");

    // R5 high level, R8 set wins over clear
    drv_pads(32'h0000_0008);
    settle();
    exp_rd(IDX_STAT, 32'h0000_0008, "R5 high level");
    drv_write(IDX_STAT, 32'h0000_0008);
    exp_rd(IDX_STAT, 32'h0000_0008, "R8 set wins");

    // R8 partial clear, zeros leave bits alone
    drv_pads(32'h0000_0028);
    settle();
    drv_pads(32'h0);
    settle();
    exp_rd(IDX_STAT, 32'h0000_0028, "R7 latched");
    drv_write(IDX_STAT, 32'h0000_0020);
    exp_rd(IDX_STAT, 32'h0000_0008, "R8 zero keeps");

    // R9 masking and line split
    exp_port(OBS_IRQ, 32'h0, "R9 masked");
    drv_write(IDX_MASK, 32'h0000_0008);
    exp_port(OBS_IRQ, 32'h1, "R9 line0");
    exp_rd(IDX_MASK, 32'h0000_0008, "R2 mask readback");
    drv_write(IDX_MASK, 32'h0010_0008);
    drv_pads(32'h0010_0000);
    settle();
    exp_port(OBS_IRQ, 32'h3, "R9 both lines");
    drv_pads(32'h0);
    settle();
    drv_write(IDX_STAT, 32'hFFFF_FFFF);
    exp_port(OBS_IRQ, 32'h0, "R9 cleared");

    // R5 edge codes, R6 both-edges override
    // pin0 rise, pin1 fall, pin2 code low (overridden), pin31 fall in upper reg
    drv_write(IDX_MASK, 32'h0);
    drv_write(IDX_CFG_LO, 32'h5555_554E);
    drv_write(IDX_CFG_HI, 32'hD555_5555);
    drv_write(IDX_EDGE, 32'h0000_0004);
    drv_write(IDX_STAT, 32'hFFFF_FFFF);
    exp_rd(IDX_STAT, 32'h0, "R6 code ignored");
    exp_rd(IDX_EDGE, 32'h0000_0004, "R2 edge readback");
    drv_pads(32'h8000_0007);
    settle();
    exp_rd(IDX_STAT, 32'h0000_0005, "R5 rise R6 both");
    drv_write(IDX_STAT, 32'h0000_0005);
    exp_rd(IDX_STAT, 32'h0, "R5 edge one-shot");
    drv_pads(32'h0);
    settle();
    exp_rd(IDX_STAT, 32'h8000_0006, "R5 fall R6 both");
    drv_write(IDX_MASK, 32'h8000_0000);
    exp_port(OBS_IRQ, 32'h2, "R9 line1 pin31");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule